// File: doc/BRIEF.md
# Concatenating Bank Selector for a Reconfigurable Cache

This block sits in front of four identical physical cache banks. It decides which banks take part in an access, so that one set of banks can act as a four-way, a two-way or a direct-mapped cache. In the narrower modes, address bits 11 and 12 join the index and steer the access to a subset of the banks. A per-bank power-off mask removes banks entirely, which shrinks the cache. For each access the block splits the address into line offset and set index and drives one enable per bank.

The block also keeps one tag and one valid bit for each set of each bank, held in register arrays. It compares the stored tags of the enabled banks with the address tag and reports a hit together with a one-hot hit bank. Software-side logic or a refill engine installs tags through a write strobe. A clear strobe drops every valid bit, and it must be pulsed whenever the associativity setting changes. Data storage, refill and replacement lie outside the block.

Top module: `wcs_bank_sel`

## Requirements
- R1: `lineOffset` equals address bits 4..0 and `setIndex` equals address bits 10..5, combinationally, in every mode.
- R2: With `cfgAssoc` = 2'b11 (four-way), every bank that is not powered off is enabled, whatever address bits 11 and 12 are.
- R3: With `cfgAssoc` = 2'b10 (two-way), banks 0 and 1 are enabled when address bit 11 is 0, and banks 2 and 3 are enabled when it is 1.
- R4: With `cfgAssoc` = 2'b00 (direct mapped), exactly one bank is enabled: bank index = {addr[11], addr[12]}. That is bank 0 for 00, bank 1 for a11=0/a12=1, bank 2 for a11=1/a12=0, and bank 3 for 11.
- R5: The reserved setting `cfgAssoc` = 2'b01 behaves exactly as four-way.
- R6: A bank whose `bankOff` bit is 1 is never enabled and never reports a hit, and a tag write aimed at it is ignored.
- R7: `hit` is 1 when some enabled bank holds a valid entry at `setIndex` whose stored tag equals address bits 31..11. `hitBank` is one-hot on the hitting bank, picks the lowest-numbered bank if several match, and is zero on a miss.
- R8: A tag write (`tagWr` = 1) stores address bits 31..11, marked valid, into bank `tagWrBank` at `setIndex` on the clock edge. A lookup in the same cycle still sees the old contents.
- R9: `invalidate` clears every valid bit on the clock edge, and it wins over a tag write in the same cycle.
- R10: Reset (`rstN` low, asynchronous) clears every valid bit, so no lookup hits until a tag is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgAssoc | input | 2 | Associativity setting: 11 four-way, 10 two-way, 00 direct, 01 reserved |
| addr | input | 32 | Access address |
| bankOff | input | 4 | Per-bank power-off mask |
| tagWr | input | 1 | Install the address tag into bank `tagWrBank` |
| tagWrBank | input | 2 | Target bank of a tag write |
| invalidate | input | 1 | Clear all valid bits |
| bankEn | output | 4 | Per-bank enables |
| setIndex | output | 6 | Set index |
| lineOffset | output | 5 | Byte offset within the 32-byte line |
| hit | output | 1 | Tag hit in an enabled bank |
| hitBank | output | 4 | One-hot hitting bank |

## Verification
Two pairs of functions can meet in one cycle. The first is a tag write and a lookup of the same address. The bench drives both together, and the scoreboard expects a miss in that cycle and a hit in the next. The second is a clear and a tag write. The bench raises `invalidate` and `tagWr` together, and the following lookup must miss. The bench model predicts every cycle from its own copy of the tag state, which it updates only after each expected item has been queued.

// File: rtl/wcs_pkg.sv
package wcs_pkg;
  localparam int NUM_BANKS = 4;
  localparam int BANK_SEL_W = $clog2(NUM_BANKS);

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_TWO    = 2'b01,
    MODE_FOUR   = 2'b10
  } assocMode_t;

  typedef struct packed {
    logic [NUM_BANKS-1:0] bankEn;
    logic [NUM_BANKS-1:0] wrEn;
    logic                 clearAll;
  } ctrlStrobes_t;
endpackage

// File: rtl/wcs_bank_ctrl.sv
module wcs_bank_ctrl
  import wcs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            cfgAssoc,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BANKS-1:0]  bankOff,
  input  logic                  tagWr,
  input  logic [BANK_SEL_W-1:0] tagWrBank,
  input  logic                  invalidate,
  output ctrlStrobes_t          strobes
);
  localparam int STEER_LO = OFFSET_W + INDEX_W;
  localparam int STEER_HI = STEER_LO + 1;

  assocMode_t mode;
  logic steerLo, steerHi;
  logic [NUM_BANKS-1:0] rawEn;

  assign steerLo = addr[STEER_LO];
  assign steerHi = addr[STEER_HI];

  always_comb begin
    unique case (cfgAssoc)
      2'b00:   mode = MODE_DIRECT;
      2'b10:   mode = MODE_TWO;
      default: mode = MODE_FOUR;
    endcase
  end

  always_comb begin
    rawEn = '0;
    unique case (mode)
      MODE_DIRECT: rawEn[{steerLo, steerHi}] = 1'b1;
      MODE_TWO:    rawEn = steerLo ? 4'b1100 : 4'b0011;
      default:     rawEn = '1;
    endcase
  end

  assign strobes.bankEn   = rawEn & ~bankOff;
  assign strobes.clearAll = invalidate;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
    assign strobes.wrEn[b] = tagWr && !invalidate && !bankOff[b]
                             && (tagWrBank == BANK_SEL_W'(b));
  end

  assert_direct_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAssoc == 2'b00) |-> $onehot0(strobes.bankEn));
  assert_two_way_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAssoc == 2'b10 && addr[STEER_LO]) |-> (strobes.bankEn[1:0] == 2'b00));
  assert_four_way_all_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgAssoc[0]) |-> (strobes.bankEn == ~bankOff));
  assert_off_never_en_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.bankEn | strobes.wrEn) & bankOff) == '0);
endmodule

// File: rtl/wcs_tag_path.sv
module wcs_tag_path
  import wcs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  ctrlStrobes_t         strobes,
  output logic [INDEX_W-1:0]   setIndex,
  output logic [OFFSET_W-1:0]  lineOffset,
  output logic                 hit,
  output logic [NUM_BANKS-1:0] hitBank
);
  localparam int TAG_LO = OFFSET_W + INDEX_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam int SETS   = 1 << INDEX_W;

  logic [TAG_W-1:0]     tagMem   [NUM_BANKS][SETS];
  logic [SETS-1:0]      validMem [NUM_BANKS];
  logic [TAG_W-1:0]     addrTag;
  logic [NUM_BANKS-1:0] match;

  assign lineOffset = addr[OFFSET_W-1:0];
  assign setIndex   = addr[TAG_LO-1:OFFSET_W];
  assign addrTag    = addr[ADDR_W-1:TAG_LO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < NUM_BANKS; b++) validMem[b] <= '0;
    end else if (strobes.clearAll) begin
      for (int b = 0; b < NUM_BANKS; b++) validMem[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (strobes.wrEn[b]) validMem[b][setIndex] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++)
      if (strobes.wrEn[b]) tagMem[b][setIndex] <= addrTag;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    assign match[b] = strobes.bankEn[b] && validMem[b][setIndex]
                      && (tagMem[b][setIndex] == addrTag);
  end

  assign hitBank = match & (~match + 1'b1);
  assign hit     = |match;

  assert_hit_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> $onehot(hitBank));
  assert_hit_in_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hitBank & ~strobes.bankEn) == '0);
  assert_clear_then_miss_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> !hit);
endmodule

// File: rtl/wcs_bank_sel.sv
module wcs_bank_sel
  import wcs_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 5,
  parameter int INDEX_W  = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            cfgAssoc,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BANKS-1:0]  bankOff,
  input  logic                  tagWr,
  input  logic [BANK_SEL_W-1:0] tagWrBank,
  input  logic                  invalidate,
  output logic [NUM_BANKS-1:0]  bankEn,
  output logic [INDEX_W-1:0]    setIndex,
  output logic [OFFSET_W-1:0]   lineOffset,
  output logic                  hit,
  output logic [NUM_BANKS-1:0]  hitBank
);
  ctrlStrobes_t strobes;

  wcs_bank_ctrl #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgAssoc(cfgAssoc), .addr(addr), .bankOff(bankOff),
    .tagWr(tagWr), .tagWrBank(tagWrBank), .invalidate(invalidate), .strobes(strobes)
  );

  wcs_tag_path #(.ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W)) path_i (
    .clk(clk), .rstN(rstN), .addr(addr), .strobes(strobes), .setIndex(setIndex),
    .lineOffset(lineOffset), .hit(hit), .hitBank(hitBank)
  );

  assign bankEn = strobes.bankEn;
endmodule

// File: tb/wcs_bank_sel_tb_top.sv
module wcs_bank_sel_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] cfgAssoc = 2'b11;
  logic [31:0] addr = '0;
  logic [3:0] bankOff = '0;
  logic tagWr = 1'b0;
  logic [1:0] tagWrBank = '0;
  logic invalidate = 1'b0;
  logic [3:0] bankEn;
  logic [5:0] setIndex;
  logic [4:0] lineOffset;
  logic hit;
  logic [3:0] hitBank;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wcs_bank_sel dut_i (
    .clk(clk), .rstN(rstN), .cfgAssoc(cfgAssoc), .addr(addr), .bankOff(bankOff),
    .tagWr(tagWr), .tagWrBank(tagWrBank), .invalidate(invalidate), .bankEn(bankEn),
    .setIndex(setIndex), .lineOffset(lineOffset), .hit(hit), .hitBank(hitBank)
  );

  logic [15:0] expQ [$];
  logic [10:0] fldQ [$];
  string reqQ [$];

  logic [20:0] mTag [4][64];
  logic        mVal [4][64];

  function automatic logic [3:0] modelEn(logic [1:0] c, logic [31:0] a, logic [3:0] off);
    logic [3:0] raw;
    case (c)
      2'b00:   raw = 4'b0001 << {a[11], a[12]};
      2'b10:   raw = a[11] ? 4'b1100 : 4'b0011;
      default: raw = 4'b1111;
    endcase
    return raw & ~off;
  endfunction

  task automatic op(input logic [1:0] c, input logic [31:0] a, input logic [3:0] off,
                    input logic wr, input logic [1:0] wb, input logic inv, input string req);
    logic [3:0] en, hb;
    logic [5:0] idx;
    @(negedge clk);
    cfgAssoc = c; addr = a; bankOff = off; tagWr = wr; tagWrBank = wb; invalidate = inv;
    en = modelEn(c, a, off);
    idx = a[10:5];
    hb = '0;
    for (int b = 3; b >= 0; b--)
      if (en[b] && mVal[b][idx] && mTag[b][idx] == a[31:11]) hb = 4'b0001 << b;
    expQ.push_back({en, |hb, hb, 7'd0});
    fldQ.push_back({idx, a[4:0]});
    reqQ.push_back(req);
    if (inv) begin
      for (int b = 0; b < 4; b++) for (int s = 0; s < 64; s++) mVal[b][s] = 1'b0;
    end else if (wr && !off[wb]) begin
      mVal[wb][idx] = 1'b1;
      mTag[wb][idx] = a[31:11];
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (expQ.size() > 0) begin
        logic [15:0] e;
        logic [10:0] f;
        string r;
        e = expQ.pop_front();
        f = fldQ.pop_front();
        r = reqQ.pop_front();
        checks++;
        if ({bankEn, hit, hitBank} !== e[15:7] || {setIndex, lineOffset} !== f) begin
          failures++;
          $display("FAIL %s: en/hit/hitBank=%b/%b/%b idx/off=%0d/%0d expected %b/%b/%b %0d/%0d",
                   r, bankEn, hit, hitBank, setIndex, lineOffset,
                   e[15:12], e[11], e[10:7], f[10:5], f[4:0]);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  localparam logic [31:0] ADDR_A = 32'h1234_4A6C;  // a11=1, a12=0
  localparam logic [31:0] ADDR_B = 32'h8000_07E1;  // a11=0, a12=0, set 63

  initial begin
    for (int b = 0; b < 4; b++) for (int s = 0; s < 64; s++) begin
      mVal[b][s] = 1'b0; mTag[b][s] = '0;
    end
    repeat (2) @(negedge clk);
    #2;
    checks++;
    if (hit !== 1'b0) begin
      failures++;
      $display("FAIL R10: hit during reset=%b expected 0", hit);
    end
    rstN = 1'b1;
    op(2'b11, ADDR_A, 4'h0, 0, 0, 0, "R10 miss after reset");
    op(2'b11, 32'h0000_1800, 4'h0, 0, 0, 0, "R2 four-way a11=a12=1");
    op(2'b11, 32'hFFFF_FFFF, 4'h0, 0, 0, 0, "R1 fields all ones");
    op(2'b11, ADDR_A, 4'h0, 1, 2, 0, "R8 write cycle sees old");
    op(2'b11, ADDR_A, 4'h0, 0, 0, 0, "R7 hit bank2");
    op(2'b10, ADDR_A, 4'h0, 0, 0, 0, "R3 two-way upper pair");
    op(2'b10, ADDR_A & ~32'h800, 4'h0, 0, 0, 0, "R3 two-way lower pair");
    op(2'b00, ADDR_A, 4'h0, 0, 0, 0, "R4 direct bank2");
    op(2'b00, ADDR_A | 32'h1000, 4'h0, 0, 0, 0, "R4 direct bank3");
    op(2'b00, ADDR_B, 4'h0, 0, 0, 0, "R4 direct bank0");
    op(2'b00, ADDR_B | 32'h1000, 4'h0, 0, 0, 0, "R4 direct bank1");
    op(2'b11, ADDR_A, 4'b0100, 0, 0, 0, "R6 off bank no hit");
    op(2'b11, ADDR_A, 4'b0010, 1, 1, 0, "R6 write to off bank");
    op(2'b11, ADDR_A, 4'h0, 0, 0, 0, "R6 off write ignored");
    op(2'b11, ADDR_A, 4'h0, 1, 0, 0, "R8 write bank0");
    op(2'b11, ADDR_A, 4'h0, 0, 0, 0, "R7 lowest bank wins");
    op(2'b01, ADDR_A, 4'h0, 0, 0, 0, "R5 reserved as four-way");
    op(2'b11, ADDR_A ^ 32'h8000_0000, 4'h0, 0, 0, 0, "R7 tag mismatch");
    op(2'b11, ADDR_B, 4'h0, 1, 3, 0, "R8 write bank3");
    op(2'b11, ADDR_B, 4'h0, 0, 0, 0, "R7 hit bank3 set 63");
    op(2'b11, ADDR_B, 4'h0, 1, 1, 1, "R9 clear and write together");
    op(2'b11, ADDR_B, 4'h0, 0, 0, 0, "R9 miss after clear");
    op(2'b11, ADDR_A, 4'h0, 0, 0, 0, "R9 old entry cleared");
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule